// File: doc/BRIEF.md
# Defect-Tolerant Tag and Replacement Controller

This block keeps the tag and flag state of a 4-way set-associative cache. It answers lookups with a hit or a miss and, on a miss, names the way that should receive the refill. Each line holds a valid flag, a lock flag and a tag. The flag pair valid=0 with lock=1 is otherwise unused, and here it marks a line that has a manufacturing fault. Such a line can never hit and is never picked for replacement, so its set works with one way fewer.

During start-up, software walks a list of known-bad lines and marks each one faulty through the configuration port. After that, ordinary lookups begin. The same port pins valid lines in place by locking them, releases locks, and invalidates lines. A lookup returns its answer one cycle after it is accepted. If a miss allocates a way, the new tag is written into that way at the same clock edge. When every way of the addressed set is locked or faulty, the miss is reported with a no-allocate flag and no state changes.

Top module: `fault_aware_tag_ctrl`

## Requirements
- R1: After reset every line is invalid and unlocked, all response outputs are 0, every replacement pointer is 0, and the first miss to any set allocates way 0.
- R2: A lookup accepted at a clock edge (req_valid=1, cfg_valid=0) raises rsp_valid for exactly the following cycle. With no accepted lookup, rsp_valid is 0.
- R3: A lookup whose tag matches a valid line of the addressed set gives rsp_hit=1 and rsp_way equal to that way, with refill_valid=0 and no change to any state.
- R4: A line marked faulty never hits, even if its stored tag equals the requested tag.
- R5: A locked line is never chosen as victim. A locked valid line still hits.
- R6: On a miss the victim is taken from the invalid unlocked ways if there are any, and otherwise from the valid unlocked ways. Within the chosen group the first way is taken, scanning upward modulo 4 from the set's pointer. After an allocation the pointer becomes victim+1 modulo 4. The tag is installed and the line made valid, and refill_valid=1 with refill_way equal to the victim.
- R7: A miss in a set whose ways are all locked or faulty gives rsp_noalloc=1, rsp_hit=0 and refill_valid=0, and changes no line.
- R8: A lookup presented in the same cycle as a configuration command is ignored: no response follows and no line is allocated.
- R9: The configuration op codes are 00 invalidate (valid=0, lock=0), 01 mark faulty (valid=0, lock=1), 10 lock (lock=1, valid kept) and 11 unlock (lock=0, valid kept). Locking an invalid line makes it faulty, and unlocking a faulty line makes it usable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_set | input | 4 | Set index of the lookup |
| req_tag | input | 8 | Tag of the lookup |
| cfg_valid | input | 1 | Configuration command strobe |
| cfg_op | input | 2 | Configuration op code |
| cfg_set | input | 4 | Set addressed by the command |
| cfg_way | input | 2 | Way addressed by the command |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 2 | Hit way (0 on a miss) |
| rsp_noalloc | output | 1 | Miss with no usable way |
| refill_valid | output | 1 | Miss allocated a way to refill |
| refill_way | output | 2 | Way to refill |

## Verification
A corrupted flag or pointer is not visible until a later lookup reaches the affected set. It then shows as a hit on a faulty line, a refill aimed at a locked way, or a victim taken out of rotation order, all one cycle after that lookup. The test sequences therefore fill each set, mark or lock its ways, and probe the same set again, so that a stale entry appears within a few lookups. Refill order is compared against hand-computed pointer positions over a full wrap-around of the pointer.

// File: rtl/fatc_pkg.sv
package fatc_pkg;
    typedef enum logic [1:0] {
        CFG_INVAL  = 2'b00,
        CFG_FAULT  = 2'b01,
        CFG_LOCK   = 2'b10,
        CFG_UNLOCK = 2'b11
    } cfg_op_e;
endpackage

// File: rtl/fatc_tag_match.sv
module fatc_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WAYS-1:0]             valid_vec,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [TAG_W-1:0]            look_tag,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way
);
    logic [WAYS-1:0] match_vec;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match_vec[g] = valid_vec[g] && (tags[g] == look_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_way = WAY_W'(i);
        end
    end
    assign hit = |match_vec;

    // R3
    one_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));
    // R4
    hit_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> valid_vec[hit_way]);
endmodule

// File: rtl/fatc_victim.sv
module fatc_victim #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WAYS-1:0]   valid_vec,
    input  logic [WAYS-1:0]   lock_vec,
    input  logic [WAY_W-1:0]  ptr,
    output logic              found,
    output logic [WAY_W-1:0]  victim
);
    logic [WAYS-1:0] free_vec;
    logic [WAYS-1:0] usable_vec;
    logic [WAYS-1:0] pick_mask;

    assign usable_vec = ~lock_vec;
    assign free_vec   = ~lock_vec & ~valid_vec;
    assign pick_mask  = (|free_vec) ? free_vec : usable_vec;
    assign found      = |usable_vec;

    always_comb begin
        logic [WAY_W-1:0] idx;
        victim = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            idx = ptr + WAY_W'(i);
            if (pick_mask[idx]) victim = idx;
        end
    end

    // R5
    victim_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> !lock_vec[victim]);
endmodule

// File: rtl/fault_aware_tag_ctrl.sv
module fault_aware_tag_ctrl
    import fatc_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [SET_W-1:0] req_set,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             cfg_valid,
    input  logic [1:0]       cfg_op,
    input  logic [SET_W-1:0] cfg_set,
    input  logic [WAY_W-1:0] cfg_way,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [WAY_W-1:0] rsp_way,
    output logic             rsp_noalloc,
    output logic             refill_valid,
    output logic [WAY_W-1:0] refill_way
);
    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]             valid;
        logic [SETS-1:0][WAYS-1:0]             lock;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][WAY_W-1:0]            ptr;
        logic                                  rsp_valid;
        logic                                  rsp_hit;
        logic [WAY_W-1:0]                      rsp_way;
        logic                                  rsp_noalloc;
        logic                                  refill_valid;
        logic [WAY_W-1:0]                      refill_way;
    } state_t;

    state_t st_d, st_q;

    logic             lk_hit;
    logic [WAY_W-1:0] lk_way;
    logic             vc_found;
    logic [WAY_W-1:0] vc_way;

    fatc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_vec (st_q.valid[req_set]),
        .tags      (st_q.tag[req_set]),
        .look_tag  (req_tag),
        .hit       (lk_hit),
        .hit_way   (lk_way)
    );

    fatc_victim #(.WAYS(WAYS)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_vec (st_q.valid[req_set]),
        .lock_vec  (st_q.lock[req_set]),
        .ptr       (st_q.ptr[req_set]),
        .found     (vc_found),
        .victim    (vc_way)
    );

    always_comb begin
        st_d              = st_q;
        st_d.rsp_valid    = 1'b0;
        st_d.rsp_hit      = 1'b0;
        st_d.rsp_way      = '0;
        st_d.rsp_noalloc  = 1'b0;
        st_d.refill_valid = 1'b0;
        st_d.refill_way   = '0;
        if (cfg_valid) begin
            case (cfg_op_e'(cfg_op))
                CFG_INVAL: begin
                    st_d.valid[cfg_set][cfg_way] = 1'b0;
                    st_d.lock[cfg_set][cfg_way]  = 1'b0;
                end
                CFG_FAULT: begin
                    st_d.valid[cfg_set][cfg_way] = 1'b0;
                    st_d.lock[cfg_set][cfg_way]  = 1'b1;
                end
                CFG_LOCK:   st_d.lock[cfg_set][cfg_way] = 1'b1;
                CFG_UNLOCK: st_d.lock[cfg_set][cfg_way] = 1'b0;
                default: ;
            endcase
        end else if (req_valid) begin
            st_d.rsp_valid = 1'b1;
            if (lk_hit) begin
                st_d.rsp_hit = 1'b1;
                st_d.rsp_way = lk_way;
            end else if (vc_found) begin
                st_d.refill_valid            = 1'b1;
                st_d.refill_way              = vc_way;
                st_d.valid[req_set][vc_way]  = 1'b1;
                st_d.tag[req_set][vc_way]    = req_tag;
                st_d.ptr[req_set]            = vc_way + WAY_W'(1);
            end else begin
                st_d.rsp_noalloc = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid    = st_q.rsp_valid;
    assign rsp_hit      = st_q.rsp_hit;
    assign rsp_way      = st_q.rsp_way;
    assign rsp_noalloc  = st_q.rsp_noalloc;
    assign refill_valid = st_q.refill_valid;
    assign refill_way   = st_q.refill_way;

    // R2
    one_cycle_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_valid) |=> rsp_valid);
    // R8
    cfg_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> !rsp_valid);
    // R3
    hit_no_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (!refill_valid && !rsp_noalloc));
    // R7
    noalloc_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_noalloc |-> (rsp_valid && !rsp_hit && !refill_valid));
endmodule

// File: tb/fault_aware_tag_ctrl_test.sv
module fault_aware_tag_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [3:0] req_set = '0;
    logic [7:0] req_tag = '0;
    logic       cfg_valid = 1'b0;
    logic [1:0] cfg_op = '0;
    logic [3:0] cfg_set = '0;
    logic [1:0] cfg_way = '0;
    logic       rsp_valid, rsp_hit, rsp_noalloc, refill_valid;
    logic [1:0] rsp_way, refill_way;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_aware_tag_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_set(req_set), .req_tag(req_tag),
        .cfg_valid(cfg_valid), .cfg_op(cfg_op), .cfg_set(cfg_set), .cfg_way(cfg_way),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_noalloc(rsp_noalloc), .refill_valid(refill_valid), .refill_way(refill_way)
    );

    typedef struct packed {
        logic [3:0] s;
        logic [7:0] t;
        logic       h;
        logic [1:0] w;
        logic       r;
        logic [1:0] rw;
        logic       n;
    } vec_t;

    // Set 1: fill, wrap the pointer, evict in rotation order (R1, R3, R6)
    localparam vec_t VEC [9] = '{
        '{4'd1, 8'h10, 1'b0, 2'd0, 1'b1, 2'd0, 1'b0},
        '{4'd1, 8'h11, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0},
        '{4'd1, 8'h10, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0},
        '{4'd1, 8'h12, 1'b0, 2'd0, 1'b1, 2'd2, 1'b0},
        '{4'd1, 8'h13, 1'b0, 2'd0, 1'b1, 2'd3, 1'b0},
        '{4'd1, 8'h14, 1'b0, 2'd0, 1'b1, 2'd0, 1'b0},
        '{4'd1, 8'h10, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0},
        '{4'd1, 8'h14, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0},
        '{4'd1, 8'h10, 1'b1, 2'd1, 1'b0, 2'd0, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic lookup(input logic [3:0] s, input logic [7:0] t);
        @(negedge clk);
        req_valid = 1'b1; req_set = s; req_tag = t;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic cfg(input logic [1:0] op, input logic [3:0] s, input logic [1:0] w);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_op = op; cfg_set = s; cfg_way = w;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string req, input logic h, input logic [1:0] w,
                              input logic r, input logic [1:0] rw, input logic n);
        chk({req, " valid"}, 8'(rsp_valid), 8'd1);
        chk({req, " hit"}, 8'(rsp_hit), 8'(h));
        chk({req, " way"}, 8'(rsp_way), 8'(w));
        chk({req, " refill"}, 8'(refill_valid), 8'(r));
        chk({req, " refill_way"}, 8'(refill_way), 8'(rw));
        chk({req, " noalloc"}, 8'(rsp_noalloc), 8'(n));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state of outputs
        chk("R1 rsp_valid", 8'(rsp_valid), 8'd0);
        chk("R1 refill", 8'(refill_valid), 8'd0);
        chk("R1 noalloc", 8'(rsp_noalloc), 8'd0);
        rst_n = 1'b1;

        for (int i = 0; i < 9; i++) begin
            lookup(VEC[i].s, VEC[i].t);
            expect_rsp($sformatf("R6/R3 vec%0d", i), VEC[i].h, VEC[i].w, VEC[i].r, VEC[i].rw, VEC[i].n);
        end

        // R2: no response without an accepted lookup
        @(negedge clk);
        chk("R2 idle rsp_valid", 8'(rsp_valid), 8'd0);

        // R8: lookup ignored while a command is present
        @(negedge clk);
        cfg_valid = 1'b1; cfg_op = 2'b11; cfg_set = 4'd9; cfg_way = 2'd0;
        req_valid = 1'b1; req_set = 4'd9; req_tag = 8'h90;
        @(negedge clk);
        cfg_valid = 1'b0; req_valid = 1'b0;
        chk("R8 rsp_valid", 8'(rsp_valid), 8'd0);
        chk("R8 refill", 8'(refill_valid), 8'd0);
        lookup(4'd9, 8'h91);   // if 0x90 had been installed, victim would be way1
        expect_rsp("R8 no install", 1'b0, 2'd0, 1'b1, 2'd0, 1'b0);

        // R4/R9: faulty line with matching stale tag never hits
        lookup(4'd2, 8'h20);
        expect_rsp("R4 fill", 1'b0, 2'd0, 1'b1, 2'd0, 1'b0);
        cfg(2'b01, 4'd2, 2'd0);
        lookup(4'd2, 8'h20);
        expect_rsp("R4 faulty miss", 1'b0, 2'd0, 1'b1, 2'd1, 1'b0);

        // R5: locked valid line pinned and still hits
        lookup(4'd3, 8'h30);
        cfg(2'b10, 4'd3, 2'd0);
        lookup(4'd3, 8'h31);
        lookup(4'd3, 8'h32);
        lookup(4'd3, 8'h33);
        expect_rsp("R6 last free", 1'b0, 2'd0, 1'b1, 2'd3, 1'b0);
        lookup(4'd3, 8'h34);
        expect_rsp("R5 skip locked", 1'b0, 2'd0, 1'b1, 2'd1, 1'b0);
        lookup(4'd3, 8'h30);
        expect_rsp("R5 pinned hit", 1'b1, 2'd0, 1'b0, 2'd0, 1'b0);

        // R7/R9: lock on invalid lines makes them faulty; full set yields no-allocate
        cfg(2'b10, 4'd4, 2'd0);
        cfg(2'b10, 4'd4, 2'd1);
        cfg(2'b01, 4'd4, 2'd2);
        lookup(4'd4, 8'h40);
        expect_rsp("R9 lock-invalid faulty", 1'b0, 2'd0, 1'b1, 2'd3, 1'b0);
        cfg(2'b10, 4'd4, 2'd3);
        lookup(4'd4, 8'h41);
        expect_rsp("R7 noalloc", 1'b0, 2'd0, 1'b0, 2'd0, 1'b1);
        lookup(4'd4, 8'h40);
        expect_rsp("R7 unchanged", 1'b1, 2'd3, 1'b0, 2'd0, 1'b0);
        cfg(2'b11, 4'd4, 2'd1);
        lookup(4'd4, 8'h42);
        expect_rsp("R9 unlock usable", 1'b0, 2'd0, 1'b1, 2'd1, 1'b0);
        cfg(2'b00, 4'd4, 2'd3);
        lookup(4'd4, 8'h40);
        expect_rsp("R9 invalidate", 1'b0, 2'd0, 1'b1, 2'd3, 1'b0);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule